// File: doc/BRIEF.md
# Clock-Enable Divider with Bypass and Safe Reprogramming

This block derives a divided clock enable from a fast source clock. An 8-bit divisor field sets the period of a one-cycle enable pulse. A bypass control makes the output follow a reference enable instead; this enable stands in for the crystal clock. Two write paths exist. The first is a direct configuration write that loads the divisor and bypass fields in one cycle. The second is a change request with a request/acknowledge handshake, which a small sequencer carries out in safe steps. No partially updated divisor ever reaches the output.

A build parameter picks one of two sequencer styles. The PLL-derived style enters bypass, loads the new divisor while bypassed, holds bypass for a set number of cycles and then releases it. The plain-divider style leaves bypass first and then loads the divisor. In both styles the acknowledge is a one-cycle pulse once the change is complete. A requested divisor too large for the field is clamped to the largest division.

Top module: `clk_en_divider`

## Requirements
- R1: A divisor field value F from 1 to 255 makes clk_en a one-cycle pulse every F source cycles. F = 0 divides by 256, and F = 1 keeps clk_en high every cycle.
- R2: The division counter restarts at every update: an accepted configuration write, a sequencer divisor load, or a sequencer bypass release. The first cycle after the update edge is cycle 1. The first pulse comes in cycle F and then every F cycles after that.
- R3: While bypass is set, clk_en equals ref_en in every cycle, whatever the divisor, and the counter is held at its start value.
- R4: A change request value of 256 or more divides by 256. A request value from 1 to 255 is used unchanged.
- R5: PLL style: on the edge that accepts a request, bypass is set. The new divisor is loaded on the next edge, while bypass is already on.
- R6: PLL style: after the load, bypass stays on for HOLD_CYC cycles and is then released. chg_ack is high for exactly one cycle, the first cycle out of bypass.
- R7: Plain style: on the edge that accepts a request, bypass is cleared and the counter restarts with the old divisor. The new divisor loads on the next edge, and chg_ack is high for exactly the following cycle.
- R8: A configuration write made while a change sequence is in progress is ignored. If a configuration write and a request arrive in the same idle cycle, the write is applied and the request is accepted one cycle later if still held.
- R9: A request is never accepted in a cycle in which chg_ack is high. The requester must drop chg_req after seeing chg_ack.
- R10: After reset the divisor field is RESET_DIV, bypass is RESET_BYP (default on, so clk_en follows ref_en), and chg_ack is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_en | input | 1 | Reference (crystal) enable, passed to clk_en in bypass |
| cfg_we | input | 1 | Direct configuration write strobe |
| cfg_div | input | DIV_W | Divisor field for a configuration write (0 = 256) |
| cfg_byp | input | 1 | Bypass bit for a configuration write |
| chg_req | input | 1 | Frequency change request, held until chg_ack |
| chg_div | input | REQ_W | Requested divisor, clamped to 256 |
| chg_ack | output | 1 | One-cycle acknowledge when a change completes |
| clk_en | output | 1 | Divided clock enable, or ref_en in bypass |

## Verification
The bench builds two copies with DIV_W = 8 and REQ_W = 12. One uses the PLL style with HOLD_CYC = 6, so the whole hold window and its release fit in a few cycles. The other uses the plain style. Both keep the full 8-bit field, so the divide-by-256 encoding and the clamp of a request of 300 are exercised at their true size. Driving both copies with the same stimulus shows how each style treats a configuration write that lands mid-sequence or together with a request, and a request still held during the acknowledge.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;

  // sequencer states; SQ_HOLD is used only by the PLL style,
  // SQ_LOAD only by the plain style
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_BYP  = 2'd1,
    SQ_HOLD = 2'd2,
    SQ_LOAD = 2'd3
  } seq_state_e;

  // one-cycle commands from the sequencer to the field registers
  typedef struct packed {
    logic set_byp;
    logic clr_byp;
    logic load;
  } seq_cmd_t;

endpackage

// File: rtl/clkdiv_counter.sv
`timescale 1ns/1ps
module clkdiv_counter #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             hold,
  input  logic [DIV_W-1:0] div_field,
  output logic             tick
);

  // the last count of a period is field-1; a zero field wraps to all ones,
  // which is exactly the period of 2**DIV_W
  function automatic logic [DIV_W-1:0] last_count(input logic [DIV_W-1:0] f);
    return f - {{(DIV_W-1){1'b0}}, 1'b1};
  endfunction

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_last;
  logic             at_last;

  assign cnt_last = last_count(div_field);
  assign at_last  = (cnt_q == cnt_last);
  assign tick     = !hold && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart || hold) begin
      cnt_q <= '0;
    end else if (at_last) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + {{(DIV_W-1){1'b0}}, 1'b1};
    end
  end

  // the field register (outside) only changes together with a restart,
  // so the count can never run past the period it selects
  assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= cnt_last);

endmodule

// File: rtl/clkdiv_seq.sv
`timescale 1ns/1ps
module clkdiv_seq
  import clkdiv_pkg::*;
#(
  parameter int REQ_W     = 12,
  parameter int DIV_W     = 8,
  parameter int HOLD_CYC  = 50,
  parameter bit PLL_STYLE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [REQ_W-1:0] req_div,
  input  logic             cfg_we,
  output logic             ack,
  output logic             busy,
  output seq_cmd_t         cmd,
  output logic [DIV_W-1:0] load_field
);

  localparam int DIV_MAX = 1 << DIV_W;

  // requests at or above the largest division map to the zero field
  function automatic logic [DIV_W-1:0] clamp_req(input logic [REQ_W-1:0] r);
    if (int'(r) >= DIV_MAX) return '0;
    return r[DIV_W-1:0];
  endfunction

  seq_state_e       state_q, state_d;
  logic             ack_q, ack_d;
  logic [DIV_W-1:0] pend_q, pend_d;
  logic             start;

  // a request waits while a direct write takes the cycle, and is not
  // taken while the previous acknowledge is still on the port
  assign start      = (state_q == SQ_IDLE) && req && !ack_q && !cfg_we;
  assign pend_d     = start ? clamp_req(req_div) : pend_q;
  assign busy       = (state_q != SQ_IDLE);
  assign ack        = ack_q;
  assign load_field = pend_q;

  generate
    if (PLL_STYLE) begin : g_pll
      localparam int HW = (HOLD_CYC < 2) ? 1 : $clog2(HOLD_CYC);
      localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYC - 1);
      logic [HW-1:0] hold_q, hold_d;

      always_comb begin
        state_d = state_q;
        cmd     = '0;
        ack_d   = 1'b0;
        hold_d  = hold_q;
        unique case (state_q)
          SQ_IDLE: begin
            if (start) begin
              cmd.set_byp = 1'b1;
              state_d     = SQ_BYP;
            end
          end
          SQ_BYP: begin
            cmd.load = 1'b1;
            hold_d   = '0;
            state_d  = SQ_HOLD;
          end
          SQ_HOLD: begin
            if (hold_q == HOLD_LAST) begin
              cmd.clr_byp = 1'b1;
              ack_d       = 1'b1;
              state_d     = SQ_IDLE;
            end else begin
              hold_d = hold_q + {{(HW-1){1'b0}}, 1'b1};
            end
          end
          default: state_d = SQ_IDLE;
        endcase
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
      end
    end else begin : g_plain
      always_comb begin
        state_d = state_q;
        cmd     = '0;
        ack_d   = 1'b0;
        unique case (state_q)
          SQ_IDLE: begin
            if (start) begin
              cmd.clr_byp = 1'b1;
              state_d     = SQ_LOAD;
            end
          end
          SQ_LOAD: begin
            cmd.load = 1'b1;
            ack_d    = 1'b1;
            state_d  = SQ_IDLE;
          end
          default: state_d = SQ_IDLE;
        endcase
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      ack_q   <= 1'b0;
      pend_q  <= '0;
    end else begin
      state_q <= state_d;
      ack_q   <= ack_d;
      pend_q  <= pend_d;
    end
  end

  assert_ack_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  assert_idle_after_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !busy);

endmodule

// File: rtl/clk_en_divider.sv
`timescale 1ns/1ps
module clk_en_divider
  import clkdiv_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int REQ_W     = 12,
  parameter int HOLD_CYC  = 50,
  parameter bit PLL_STYLE = 1'b1,
  parameter int RESET_DIV = 4,
  parameter bit RESET_BYP = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_en,
  input  logic             cfg_we,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_byp,
  input  logic             chg_req,
  input  logic [REQ_W-1:0] chg_div,
  output logic             chg_ack,
  output logic             clk_en
);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] load_field;
  logic             byp_q;
  logic             busy;
  logic             tick;
  logic             cfg_take;
  logic             restart;
  seq_cmd_t         cmd;

  clkdiv_seq #(
    .REQ_W    (REQ_W),
    .DIV_W    (DIV_W),
    .HOLD_CYC (HOLD_CYC),
    .PLL_STYLE(PLL_STYLE)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (chg_req),
    .req_div   (chg_div),
    .cfg_we    (cfg_we),
    .ack       (chg_ack),
    .busy      (busy),
    .cmd       (cmd),
    .load_field(load_field)
  );

  // named events for the checks below
  assign cfg_take = cfg_we && !busy;
  assign restart  = cfg_take || cmd.load || cmd.clr_byp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= DIV_W'(RESET_DIV);
      byp_q <= RESET_BYP;
    end else if (cfg_take) begin
      div_q <= cfg_div;
      byp_q <= cfg_byp;
    end else begin
      if (cmd.set_byp) byp_q <= 1'b1;
      if (cmd.clr_byp) byp_q <= 1'b0;
      if (cmd.load)    div_q <= load_field;
    end
  end

  clkdiv_counter #(
    .DIV_W(DIV_W)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .hold     (byp_q),
    .div_field(div_q),
    .tick     (tick)
  );

  assign clk_en = byp_q ? ref_en : tick;

  assert_ack_out_of_byp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    chg_ack |-> !byp_q);

  assert_cfg_ignored_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && busy && (cmd == '0)) |=> ($stable(div_q) && $stable(byp_q)));

  generate
    if (PLL_STYLE) begin : g_pll_chk
      localparam int SW = $clog2(HOLD_CYC + 1);
      logic [SW-1:0] since_load;

      // cycles elapsed since the last divisor load, saturating
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          since_load <= '0;
        else if (cmd.load)                   since_load <= '0;
        else if (since_load != SW'(HOLD_CYC)) since_load <= since_load + {{(SW-1){1'b0}}, 1'b1};
      end

      assert_byp_before_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.load |-> byp_q);

      assert_hold_min_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.clr_byp |-> (since_load >= SW'(HOLD_CYC - 1)));
    end else begin : g_plain_chk
      assert_unbyp_before_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.load |-> !byp_q);
    end
  endgenerate

endmodule

// File: tb/test_clk_en_divider.sv
`timescale 1ns/1ps
module test_clk_en_divider;

  localparam int DIV_W = 8;
  localparam int REQ_W = 12;
  localparam int HOLD  = 6;
  localparam bit P = 1'b0;   // PLL-style copy
  localparam bit S = 1'b1;   // plain-style copy

  typedef struct packed {
    logic [1:0] code;   // 0 / 1 literal, 2 = must equal ref_en
    logic       ack;
    logic [7:0] tag;    // requirement number for the message
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_en = 1'b0;
  logic cfg_we = 1'b0;
  logic [DIV_W-1:0] cfg_div = '0;
  logic cfg_byp = 1'b0;
  logic chg_req = 1'b0;
  logic [REQ_W-1:0] chg_div = '0;
  logic ack_p, en_p, ack_s, en_s;

  int n_chk = 0;
  int n_bad = 0;
  item_t q_p[$];
  item_t q_s[$];
  item_t mon_p, mon_s;

  always #2 clk = ~clk;

  clk_en_divider #(.DIV_W(DIV_W), .REQ_W(REQ_W), .HOLD_CYC(HOLD), .PLL_STYLE(1'b1),
                   .RESET_DIV(4), .RESET_BYP(1'b1)) i_clk_en_divider (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .cfg_we(cfg_we), .cfg_div(cfg_div),
    .cfg_byp(cfg_byp), .chg_req(chg_req), .chg_div(chg_div), .chg_ack(ack_p), .clk_en(en_p));

  clk_en_divider #(.DIV_W(DIV_W), .REQ_W(REQ_W), .HOLD_CYC(HOLD), .PLL_STYLE(1'b0),
                   .RESET_DIV(4), .RESET_BYP(1'b1)) i_clk_en_divider_plain (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .cfg_we(cfg_we), .cfg_div(cfg_div),
    .cfg_byp(cfg_byp), .chg_req(chg_req), .chg_div(chg_div), .chg_ack(ack_s), .clk_en(en_s));

  // reference enable: high one cycle in three, changed just after posedge
  initial begin
    int ph = 0;
    forever begin
      @(posedge clk);
      #1;
      ph = (ph == 2) ? 0 : ph + 1;
      ref_en = (ph == 0);
    end
  end

  // ---------------- scoreboard ----------------
  function automatic void push(bit sel, logic [1:0] code, logic ack, int tag);
    item_t it;
    it.code = code;
    it.ack  = ack;
    it.tag  = 8'(tag);
    if (sel) q_s.push_back(it);
    else     q_p.push_back(it);
  endfunction

  // fresh divide-by-n pattern: pulse in the n-th cycle after the update
  function automatic void push_run(bit sel, int n, int len, logic first_ack, int tag);
    for (int k = 0; k < len; k++)
      push(sel, ((k % n) == n - 1) ? 2'd1 : 2'd0, (k == 0) ? first_ack : 1'b0, tag);
  endfunction

  function automatic void push_byp(bit sel, int len, int tag);
    for (int k = 0; k < len; k++) push(sel, 2'd2, 1'b0, tag);
  endfunction

  task automatic compare(string who, item_t it, logic en, logic ack);
    logic exp_en;
    exp_en = (it.code == 2'd2) ? ref_en : it.code[0];
    n_chk++;
    if (en !== exp_en || ack !== it.ack) begin
      n_bad++;
      $display("FAIL R%0d %s: clk_en=%b chg_ack=%b expected clk_en=%b chg_ack=%b",
               it.tag, who, en, ack, exp_en, it.ack);
    end
  endtask

  always @(negedge clk) begin
    if (q_p.size() != 0) begin
      mon_p = q_p.pop_front();
      compare("pll", mon_p, en_p, ack_p);
    end
    if (q_s.size() != 0) begin
      mon_s = q_s.pop_front();
      compare("plain", mon_s, en_s, ack_s);
    end
  end

  // ---------------- driver ----------------
  task automatic drive_cfg(logic [DIV_W-1:0] d, logic b);
    @(negedge clk);
    cfg_we = 1'b1; cfg_div = d; cfg_byp = b;
    #1;
  endtask

  task automatic drive_req(int d);
    @(negedge clk);
    chg_req = 1'b1; chg_div = REQ_W'(d);
    #1;
  endtask

  task automatic drain();
    @(negedge clk);
    cfg_we = 1'b0; chg_req = 1'b0;
    #1;
    while (q_p.size() != 0 || q_s.size() != 0) begin
      @(negedge clk);
      #1;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10 reset state: bypass on, ack low; R3 output follows ref_en
    push_byp(P, 6, 10); push_byp(S, 6, 10);
    drain();

    // R1 / R2: divide by 5 after a direct write
    drive_cfg(8'd5, 1'b0);
    push_run(P, 5, 16, 1'b0, 1); push_run(S, 5, 16, 1'b0, 1);
    drain();

    // R1: zero field divides by 256
    drive_cfg(8'd0, 1'b0);
    push_run(P, 256, 520, 1'b0, 1); push_run(S, 256, 520, 1'b0, 1);
    drain();

    // R1: field 1 pulses every cycle
    drive_cfg(8'd1, 1'b0);
    push_run(P, 1, 5, 1'b0, 1); push_run(S, 1, 5, 1'b0, 1);
    drain();

    // R3: bypass overrides divisor 7
    drive_cfg(8'd7, 1'b1);
    push_byp(P, 8, 3); push_byp(S, 8, 3);
    drain();
    // R2: leaving bypass by a write restarts the count
    drive_cfg(8'd7, 1'b0);
    push_run(P, 7, 15, 1'b0, 2); push_run(S, 7, 15, 1'b0, 2);
    drain();

    // R2: rewrite mid-period restarts from the beginning
    drive_cfg(8'd4, 1'b0);
    push_run(P, 4, 6, 1'b0, 2); push_run(S, 4, 6, 1'b0, 2);
    drain();
    drive_cfg(8'd4, 1'b0);
    push_run(P, 4, 9, 1'b0, 2); push_run(S, 4, 9, 1'b0, 2);
    drain();

    // R5 / R6 (PLL) and R7 (plain): change to 9
    drive_req(9);
    push_byp(P, HOLD + 1, 5); push_run(P, 9, 20, 1'b1, 6);
    push(S, 2'd0, 1'b0, 7);   push_run(S, 9, 20, 1'b1, 7);
    drain();

    // R4: request of 300 clamps to divide by 256
    drive_req(300);
    push_byp(P, HOLD + 1, 5); push_run(P, 256, 262, 1'b1, 4);
    push(S, 2'd0, 1'b0, 7);   push_run(S, 256, 262, 1'b1, 4);
    drain();

    // R8: write during the PLL hold is ignored; the idle plain copy takes it
    drive_req(2);
    push_byp(P, HOLD + 1, 8); push_run(P, 2, 10, 1'b1, 8);
    push(S, 2'd0, 1'b0, 7); push(S, 2'd0, 1'b1, 7); push(S, 2'd1, 1'b0, 7);
    push_run(S, 3, 12, 1'b0, 8);
    @(negedge clk); chg_req = 1'b0;
    @(negedge clk);
    @(negedge clk); cfg_we = 1'b1; cfg_div = 8'd3; cfg_byp = 1'b0;
    drain();

    // R8: write and request together: write first, request one cycle later
    @(negedge clk);
    cfg_we = 1'b1; cfg_div = 8'd3; cfg_byp = 1'b0;
    chg_req = 1'b1; chg_div = REQ_W'(6);
    #1;
    push(P, 2'd0, 1'b0, 8); push_byp(P, HOLD + 1, 5); push_run(P, 6, 14, 1'b1, 6);
    push(S, 2'd0, 1'b0, 8); push(S, 2'd0, 1'b0, 7);  push_run(S, 6, 14, 1'b1, 7);
    @(negedge clk); cfg_we = 1'b0;
    drain();

    // R9: request held through the acknowledge is not taken again
    drive_req(5);
    push_byp(P, HOLD + 1, 5); push_run(P, 5, 12, 1'b1, 6);
    push(S, 2'd0, 1'b0, 7);   push_run(S, 5, 12, 1'b1, 9);
    @(negedge clk);
    @(negedge clk);
    @(negedge clk); chg_req = 1'b0;
    drain();

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R10 watchdog: finished=0 expected finished=1");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule